// File: doc/BRIEF.md
# Dual-Port RAM Mailbox Interrupts

A synchronous two-port word memory in which a left and a right agent each read and write the whole array independently, through their own select, output enable, write select, address and data lines. All accesses are sampled on one shared clock edge, and read data comes out of a register one edge after the read.

The top two words of the array double as cross-port mailboxes. The word at `DEPTH-2` is addressed to the left agent: a write to it from the right side raises the left agent's active-low interrupt. The word at `DEPTH-1` is addressed to the right agent in the same way. Each receiving side acknowledges by accessing its own mailbox. The message itself is ordinary stored data. The parameter `MBOX_EN` set to 0 removes the interrupt function, and both top words then behave like any other location.

Top module: `dpram_mailbox`

## Requirements
- R1: A port with `ce_ni`=0 and `we_ni`=0 stores `wdata_i` at `addr_i`. A port with `ce_ni`=0, `we_ni`=1 and `oe_ni`=0 reads. The read word appears on `rdata_o` after that clock edge and holds until the next read.
- R2: A port with `ce_ni`=1 is deselected. It writes nothing, its `rdata_o` holds, and it changes no interrupt flag.
- R3: A right-port write to address `DEPTH-2` drives `l_irq_no` low after that edge. It stays low until the left agent clears it.
- R4: A left-port cycle with `ce_ni`=0 and `oe_ni`=0 at address `DEPTH-2` clears the left interrupt (`l_irq_no` returns to 1), whatever the level of `we_ni`. The same cycle with `oe_ni`=1 does not clear it.
- R5: A left-port write to address `DEPTH-1` drives `r_irq_no` low after that edge.
- R6: A right-port read (`ce_ni`=0, `we_ni`=1, `oe_ni`=0) of address `DEPTH-1` clears the right interrupt. A right-port write there, or a cycle with `oe_ni`=1, does not clear it.
- R7: When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R8: Both mailbox words store and return 16-bit data like any other word, and either port can read them.
- R9: With `MBOX_EN`=0, `l_irq_no` and `r_irq_no` stay 1 at all times. The top two words behave as ordinary memory.
- R10: While `rst_ni`=0, both interrupt outputs are 1 and both `rdata_o` are 0. Memory contents survive reset.
- R11: If both ports write the same address in one cycle, the left data is stored. A read concurrent with a write from the other port to the same address returns the old word.
- R12: A port with `ce_ni`=0, `we_ni`=1 and `oe_ni`=1 performs no read, and its `rdata_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left select, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_we_ni | input | 1 | Left write select, 0 = write |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_irq_no | output | 1 | Left interrupt, active low |
| r_ce_ni | input | 1 | Right select, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_we_ni | input | 1 | Right write select, 0 = write |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_irq_no | output | 1 | Right interrupt, active low |

## Verification
The only internal state is the stored words, the two interrupt flags and the two read registers. A wrong flag shows on the matching `irq_no` pin at the very next edge. A set or clear that is lost or misrouted therefore shows within one cycle of the triggering access. A corrupted word stays hidden until some port reads that address, and it then shows one edge after the read. The bench therefore rereads the mailbox words and a small pool of hot addresses often. Collision ordering and read-before-write only show when both ports target one address in the same cycle, so the stimulus steers both ports onto shared addresses.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;
  localparam int unsigned SIDES  = 2;
  localparam int unsigned SIDE_L = 0;
  localparam int unsigned SIDE_R = 1;

  typedef struct packed {
    logic wr;    // selected write
    logic rd;    // selected read with output enabled
    logic look;  // selected with output enabled, any direction
  } dpm_acc_t;
endpackage

// File: rtl/dpm_port_dec.sv
`timescale 1ns/1ps
module dpm_port_dec
  import dpm_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OWN_MB  = '0,
  parameter logic [ADDR_W-1:0] PEER_MB = '0
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output dpm_acc_t          acc_o,
  output logic              at_own_o,
  output logic              at_peer_o
);
  always_comb begin
    acc_o.wr   = !ce_ni && !we_ni;
    acc_o.rd   = !ce_ni &&  we_ni && !oe_ni;
    acc_o.look = !ce_ni && !oe_ni;
  end

  assign at_own_o  = (addr_i == OWN_MB);
  assign at_peer_o = (addr_i == PEER_MB);
endmodule

// File: rtl/dpm_store.sv
`timescale 1ns/1ps
module dpm_store
  import dpm_pkg::*;
#(
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i    [SIDES],
  input  logic              rd_i    [SIDES],
  input  logic [ADDR_W-1:0] addr_i  [SIDES],
  input  logic [DATA_W-1:0] wdata_i [SIDES],
  output logic [DATA_W-1:0] rdata_o [SIDES]
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // Left write is applied last so it wins a same-address collision.
  always_ff @(posedge clk_i) begin
    if (wr_i[SIDE_R]) mem_q[addr_i[SIDE_R]] <= wdata_i[SIDE_R];
    if (wr_i[SIDE_L]) mem_q[addr_i[SIDE_L]] <= wdata_i[SIDE_L];
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_rd
    logic [DATA_W-1:0] rdata_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (rd_i[s]) rdata_q <= mem_q[addr_i[s]];
    end
    assign rdata_o[s] = rdata_q;
  end
endmodule

// File: rtl/dpm_irq_flag.sv
`timescale 1ns/1ps
module dpm_irq_flag #(
  parameter bit EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  if (EN) begin : g_on
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;  // set beats clear
      else if (clr_i)  flag_q <= 1'b0;
    end
    assign irq_no = ~flag_q;
  end else begin : g_off
    logic unused_flag;
    assign unused_flag = ^{clk_i, rst_ni, set_i, clr_i};
    assign irq_no = 1'b1;
  end
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned DATA_W  = 16,
  parameter bit          MBOX_EN = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_oe_ni,
  input  logic              l_we_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_irq_no,
  input  logic              r_ce_ni,
  input  logic              r_oe_ni,
  input  logic              r_we_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] MB_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] MB_R = ADDR_W'(DEPTH - 1);

  logic              ce_n   [SIDES];
  logic              oe_n   [SIDES];
  logic              we_n   [SIDES];
  logic [ADDR_W-1:0] addr   [SIDES];
  logic [DATA_W-1:0] wdata  [SIDES];
  logic [DATA_W-1:0] rdata  [SIDES];
  dpm_acc_t          acc    [SIDES];
  logic              at_own [SIDES];
  logic              at_peer[SIDES];
  logic              wr     [SIDES];
  logic              rd     [SIDES];
  logic              irq_n  [SIDES];

  assign ce_n[SIDE_L]  = l_ce_ni;   assign ce_n[SIDE_R]  = r_ce_ni;
  assign oe_n[SIDE_L]  = l_oe_ni;   assign oe_n[SIDE_R]  = r_oe_ni;
  assign we_n[SIDE_L]  = l_we_ni;   assign we_n[SIDE_R]  = r_we_ni;
  assign addr[SIDE_L]  = l_addr_i;  assign addr[SIDE_R]  = r_addr_i;
  assign wdata[SIDE_L] = l_wdata_i; assign wdata[SIDE_R] = r_wdata_i;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == SIDE_L) ? MB_L : MB_R;
    localparam logic [ADDR_W-1:0] PEER = (s == SIDE_L) ? MB_R : MB_L;
    localparam int unsigned       OTH  = SIDES - 1 - s;

    logic set_s, clr_s;

    dpm_port_dec #(
      .ADDR_W (ADDR_W),
      .OWN_MB (OWN),
      .PEER_MB(PEER)
    ) i_dec (
      .ce_ni    (ce_n[s]),
      .oe_ni    (oe_n[s]),
      .we_ni    (we_n[s]),
      .addr_i   (addr[s]),
      .acc_o    (acc[s]),
      .at_own_o (at_own[s]),
      .at_peer_o(at_peer[s])
    );

    assign wr[s] = acc[s].wr;
    assign rd[s] = acc[s].rd;

    // Raised by the opposite port writing this side's mailbox.
    assign set_s = acc[OTH].wr && at_peer[OTH];

    // Left acknowledges on any output-enabled access, right only on a read.
    if (s == SIDE_L) begin : g_clr_look
      assign clr_s = acc[s].look && at_own[s];
    end else begin : g_clr_read
      assign clr_s = acc[s].rd && at_own[s];
    end

    dpm_irq_flag #(.EN(MBOX_EN)) i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_s),
      .clr_i (clr_s),
      .irq_no(irq_n[s])
    );
  end

  dpm_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .rd_i   (rd),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  assign l_rdata_o = rdata[SIDE_L];
  assign r_rdata_o = rdata[SIDE_R];
  assign l_irq_no  = irq_n[SIDE_L];
  assign r_irq_no  = irq_n[SIDE_R];
endmodule

// File: rtl/dpm_mailbox_chk.sv
`timescale 1ns/1ps
module dpm_mailbox_chk #(
  parameter int unsigned DEPTH   = 4096,
  parameter int unsigned DATA_W  = 16,
  parameter bit          MBOX_EN = 1'b1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_ni,
  input logic              l_oe_ni,
  input logic              l_we_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_wdata_i,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_irq_no,
  input logic              r_ce_ni,
  input logic              r_oe_ni,
  input logic              r_we_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [DATA_W-1:0] r_wdata_i,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] MB_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] MB_R = ADDR_W'(DEPTH - 1);

  logic unused_wd;
  assign unused_wd = ^{l_wdata_i, r_wdata_i};

  logic set_l, clr_l, set_r, clr_r;
  assign set_l = MBOX_EN && !r_ce_ni && !r_we_ni && (r_addr_i == MB_L);
  assign clr_l = MBOX_EN && !l_ce_ni && !l_oe_ni && (l_addr_i == MB_L);
  assign set_r = MBOX_EN && !l_ce_ni && !l_we_ni && (l_addr_i == MB_R);
  assign clr_r = MBOX_EN && !r_ce_ni && r_we_ni && !r_oe_ni && (r_addr_i == MB_R);

  assert_lirq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_l |=> !l_irq_no);
  assert_lirq_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_l && !set_l) |=> l_irq_no);
  assert_rirq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_r |=> !r_irq_no);
  assert_rirq_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_r && !set_r) |=> r_irq_no);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_l && clr_l) |=> !l_irq_no);
  assert_lirq_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_l && !clr_l) |=> $stable(l_irq_no));
  assert_rirq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_r && !clr_r) |=> $stable(r_irq_no));
  assert_irq_off_R9: assert property (@(posedge clk_i)
    !MBOX_EN |-> (l_irq_no && r_irq_no));
  assert_ldesel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_ce_ni |=> $stable(l_rdata_o));
  assert_rdesel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ce_ni |=> $stable(r_rdata_o));
  assert_loe_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_oe_ni && l_we_ni) |=> $stable(l_rdata_o));
  assert_roe_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_oe_ni && r_we_ni) |=> $stable(r_rdata_o));
  assert_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (l_irq_no && r_irq_no && l_rdata_o == '0 && r_rdata_o == '0));
endmodule

bind dpram_mailbox dpm_mailbox_chk #(
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W),
  .MBOX_EN(MBOX_EN)
) i_chk (.*);

// File: tb/test_dpram_mailbox.sv
`timescale 1ns/1ps
module test_dpram_mailbox;
  localparam int DEPTH = 4096;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] LMB = AW'(DEPTH - 2);
  localparam logic [AW-1:0] RMB = AW'(DEPTH - 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_ni;
  logic          l_ce, l_oe, l_we, r_ce, r_oe, r_we;
  logic [AW-1:0] l_ad, r_ad;
  logic [DW-1:0] l_wd, r_wd;
  logic [DW-1:0] l_rd, r_rd, x_l_rd, x_r_rd;
  logic          l_irq, r_irq, x_l_irq, x_r_irq;

  dpram_mailbox #(.DEPTH(DEPTH), .DATA_W(DW), .MBOX_EN(1'b1)) i_dpram_mailbox (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(l_ce), .l_oe_ni(l_oe), .l_we_ni(l_we), .l_addr_i(l_ad), .l_wdata_i(l_wd),
    .l_rdata_o(l_rd), .l_irq_no(l_irq),
    .r_ce_ni(r_ce), .r_oe_ni(r_oe), .r_we_ni(r_we), .r_addr_i(r_ad), .r_wdata_i(r_wd),
    .r_rdata_o(r_rd), .r_irq_no(r_irq));

  dpram_mailbox #(.DEPTH(DEPTH), .DATA_W(DW), .MBOX_EN(1'b0)) i_dpram_mailbox_off (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(l_ce), .l_oe_ni(l_oe), .l_we_ni(l_we), .l_addr_i(l_ad), .l_wdata_i(l_wd),
    .l_rdata_o(x_l_rd), .l_irq_no(x_l_irq),
    .r_ce_ni(r_ce), .r_oe_ni(r_oe), .r_we_ni(r_we), .r_addr_i(r_ad), .r_wdata_i(r_wd),
    .r_rdata_o(x_r_rd), .r_irq_no(x_r_irq));

  logic [DW-1:0] mm [DEPTH];
  bit            kn [DEPTH];
  logic [DW-1:0] e_lrd, e_rrd;
  bit            e_lk, e_rk, f_l, f_r;
  int            checks = 0;
  int            fails  = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drv_l(input logic ce, oe, we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_oe = oe; l_we = we; l_ad = a; l_wd = d;
  endtask

  task automatic drv_r(input logic ce, oe, we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_oe = oe; r_we = we; r_ad = a; r_wd = d;
  endtask

  task automatic idle();
    drv_l(1, 1, 1, '0, '0);
    drv_r(1, 1, 1, '0, '0);
  endtask

  // Advances one cycle with the driven inputs, updates the model, checks at negedge.
  task automatic step(input string td, input string ti);
    bit lwr, lrdq, llook, rwr, rrdq, sl, cl, sr, cr;
    lwr   = !l_ce && !l_we;
    lrdq  = !l_ce && l_we && !l_oe;
    llook = !l_ce && !l_oe;
    rwr   = !r_ce && !r_we;
    rrdq  = !r_ce && r_we && !r_oe;
    @(posedge clk);
    if (lrdq) begin e_lrd = mm[l_ad]; e_lk = kn[l_ad]; end
    if (rrdq) begin e_rrd = mm[r_ad]; e_rk = kn[r_ad]; end
    if (rwr) begin mm[r_ad] = r_wd; kn[r_ad] = 1; end
    if (lwr) begin mm[l_ad] = l_wd; kn[l_ad] = 1; end
    sl = rwr && (r_ad == LMB);
    cl = llook && (l_ad == LMB);
    sr = lwr && (l_ad == RMB);
    cr = rrdq && (r_ad == RMB);
    f_l = sl ? 1'b1 : (cl ? 1'b0 : f_l);
    f_r = sr ? 1'b1 : (cr ? 1'b0 : f_r);
    @(negedge clk);
    if (e_lk) begin
      chk(td, "l_rdata", 32'(l_rd), 32'(e_lrd));
      chk(td, "off l_rdata", 32'(x_l_rd), 32'(e_lrd));
    end
    if (e_rk) begin
      chk(td, "r_rdata", 32'(r_rd), 32'(e_rrd));
      chk(td, "off r_rdata", 32'(x_r_rd), 32'(e_rrd));
    end
    chk(ti, "l_irq_no", 32'(l_irq), 32'(!f_l));
    chk(ti, "r_irq_no", 32'(r_irq), 32'(!f_r));
    chk("R9", "off l_irq_no", 32'(x_l_irq), 32'd1);
    chk("R9", "off r_irq_no", 32'(x_r_irq), 32'd1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle();
    f_l = 0; f_r = 0; e_lrd = '0; e_rrd = '0; e_lk = 1; e_rk = 1;
    repeat (2) @(negedge clk);
    chk("R10", "l_irq_no in reset", 32'(l_irq), 32'd1);
    chk("R10", "r_irq_no in reset", 32'(r_irq), 32'd1);
    chk("R10", "l_rdata in reset", 32'(l_rd), 32'd0);
    chk("R10", "r_rdata in reset", 32'(r_rd), 32'd0);
    rst_ni = 1'b1;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int unsigned k = $urandom % 8;
    if (k < 4)  return AW'(k);
    if (k == 4) return LMB;
    if (k == 5) return RMB;
    return AW'($urandom % DEPTH);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) kn[i] = 0;
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 basic write then read on both ports
    drv_l(0, 1, 0, 12'd5, 16'hA5A5); step("R1", "R1");
    drv_r(0, 1, 0, 12'd6, 16'h0F0F); step("R1", "R1");
    drv_l(0, 0, 1, 12'd6, '0); drv_r(0, 0, 1, 12'd5, '0); step("R1", "R1");
    chk("R1", "l_rdata direct", 32'(l_rd), 32'h0F0F);
    chk("R1", "r_rdata direct", 32'(r_rd), 32'hA5A5);

    // R2 deselected write is dropped, rdata holds
    idle(); drv_l(1, 0, 0, 12'd5, 16'h1111); step("R2", "R2");
    drv_l(0, 0, 1, 12'd5, '0); drv_r(1, 0, 1, 12'd5, '0); step("R2", "R2");
    chk("R2", "deselected write dropped", 32'(l_rd), 32'hA5A5);

    // R12 oe high read holds rdata
    drv_l(0, 1, 1, 12'd6, '0); drv_r(1, 1, 1, '0, '0); step("R12", "R12");
    chk("R12", "oe high holds", 32'(l_rd), 32'hA5A5);

    // R3 right writes the left mailbox
    drv_l(1, 1, 1, '0, '0); drv_r(0, 1, 0, LMB, 16'h1234); step("R3", "R3");
    chk("R3", "l_irq_no after set", 32'(l_irq), 32'd0);
    drv_r(0, 0, 1, LMB, '0); step("R8", "R3");  // right reads it, no clear
    chk("R8", "mailbox data via right", 32'(r_rd), 32'h1234);
    chk("R3", "l_irq_no held", 32'(l_irq), 32'd0);

    // R4 oe high access does not clear, oe low write does
    drv_r(1, 1, 1, '0, '0); drv_l(0, 1, 0, LMB, 16'h2222); step("R4", "R4");
    chk("R4", "oe high no clear", 32'(l_irq), 32'd0);
    drv_l(0, 0, 0, LMB, 16'h3333); step("R4", "R4");
    chk("R4", "clear with we low", 32'(l_irq), 32'd1);
    drv_l(1, 1, 1, '0, '0); drv_r(0, 1, 0, LMB, 16'h4444); step("R3", "R3");
    drv_r(1, 1, 1, '0, '0); drv_l(0, 0, 1, LMB, '0); step("R8", "R4");
    chk("R4", "clear with read", 32'(l_irq), 32'd1);
    chk("R8", "mailbox data via left", 32'(l_rd), 32'h4444);

    // R5, R6 right mailbox
    drv_l(0, 1, 0, RMB, 16'h5555); step("R5", "R5");
    chk("R5", "r_irq_no after set", 32'(r_irq), 32'd0);
    drv_l(1, 1, 1, '0, '0); drv_r(0, 0, 0, RMB, 16'h6666); step("R6", "R6");
    chk("R6", "right write no clear", 32'(r_irq), 32'd0);
    drv_r(0, 1, 1, RMB, '0); step("R6", "R6");
    chk("R6", "oe high no clear", 32'(r_irq), 32'd0);
    drv_r(0, 0, 1, RMB, '0); step("R6", "R6");
    chk("R6", "read clears", 32'(r_irq), 32'd1);
    chk("R8", "right mailbox data", 32'(r_rd), 32'h6666);

    // R7 set wins over clear
    drv_r(0, 1, 0, LMB, 16'h7777); drv_l(0, 0, 1, LMB, '0); step("R7", "R7");
    chk("R7", "left set wins", 32'(l_irq), 32'd0);
    drv_l(0, 1, 0, RMB, 16'h8888); drv_r(0, 0, 1, RMB, '0); step("R7", "R7");
    chk("R7", "right set wins", 32'(r_irq), 32'd0);
    chk("R11", "read old during write", 32'(r_rd), 32'h6666);

    // R11 collision
    drv_l(0, 1, 0, 12'd9, 16'hAAAA); drv_r(0, 1, 0, 12'd9, 16'hBBBB); step("R11", "R11");
    drv_l(0, 1, 0, 12'd9, 16'hCCCC); drv_r(0, 0, 1, 12'd9, '0); step("R11", "R11");
    chk("R11", "left wins collision", 32'(r_rd), 32'hAAAA);

    // R10 reset with flags set, memory retained
    idle(); @(negedge clk);
    do_reset();
    drv_l(0, 0, 1, 12'd5, '0); drv_r(0, 0, 1, 12'd9, '0); step("R10", "R10");
    chk("R10", "memory kept l", 32'(l_rd), 32'hA5A5);
    chk("R10", "memory kept r", 32'(r_rd), 32'hCCCC);

    // Random traffic around hot addresses and mailboxes
    for (int n = 0; n < 4000; n++) begin
      drv_l(($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2, pick_addr(), DW'($urandom));
      drv_r(($urandom % 4) == 0, ($urandom % 4) == 0, $urandom % 2, pick_addr(), DW'($urandom));
      step("R1", "R3");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule